// File: doc/BRIEF.md
# Static Memory Read Timing Controller

The block runs read accesses to asynchronous static memories such as SRAM, flash or ROM, in the bus clock domain. A requester presents an address and a bank number. The controller then drives the address bus and the active-low chip select of that bank. It pulls the shared active-low output enable low after a per-bank delay, and holds the strobes for a per-bank number of wait states. At the sample edge it latches the memory's data word and releases both strobes together. It keeps the address on the bus for one more clock, then returns to idle.

Each bank has two timing fields, and both are loaded through a small register write port:
- a 4-bit output-enable delay, counted in clocks from chip select;
- a 5-bit read wait-state count.

Both values are captured when a request is accepted, so a write to a bank's fields never alters an access that is already running. Completion is reported by a one-clock done pulse that carries the captured word.

Top module: `smem_rd_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, every chip select and the output enable are high, busy_o is low and done_o is low.
- R2: A request (req_i high while busy_o is low) is accepted at the clock edge. In the following cycle busy_o is high, mem_addr_o equals the request address, and mem_cs_no is low only in bit req_bank_i.
- R3: With an output-enable delay of 0, mem_oe_no goes low in the same cycle as the chip select.
- R4: With an output-enable delay of D>0, mem_oe_no goes low D cycles after the chip select goes low.
- R5: For a wait count W and an output-enable delay D, the chip select stays low for max(W,D)+1 cycles, and the data is sampled at the clock edge that ends the last of those cycles. With W=0 and D=0 this is the first edge after the address becomes valid, and each wait state adds exactly one clock. Output enable is therefore always low for at least one clock before the sample.
- R6: Chip select and output enable return high at the same clock edge, which is the sample edge.
- R7: done_o is high for exactly one cycle, the cycle after the sample edge. In that cycle rd_data_o holds the word that the memory drove at the sample edge, and rd_data_o keeps that word until the next done pulse.
- R8: In the cycle after the sample edge, the address stays unchanged and busy_o stays high while both strobes are high (address hold). busy_o goes low in the next cycle, and only then is a new request accepted.
- R9: A request that arrives while busy_o is high is ignored. It neither changes the address nor the current access, and it starts no access after the current one ends.
- R10: A write with cfg_we_i high loads the wait count and output-enable delay of bank cfg_bank_i only; the fields of every other bank are unchanged. Both fields reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the timing fields |
| cfg_bank_i | input | 2 | Bank whose fields are written |
| cfg_wait_i | input | 5 | Read wait-state count to write |
| cfg_oed_i | input | 4 | Output-enable delay to write |
| req_i | input | 1 | Read request |
| req_addr_i | input | 24 | Read address |
| req_bank_i | input | 2 | Bank to access |
| busy_o | output | 1 | Access or address hold in progress |
| mem_addr_o | output | 24 | Memory address bus |
| mem_cs_no | output | 4 | Chip selects, active low, one per bank |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_data_i | input | 32 | Memory read data |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 32 | Captured read word |

## Verification
The assertions check on every cycle that:
- the strobes stay high when idle;
- at most one chip select is low;
- chip select and output enable rise together, at the sample edge;
- output enable was low in the cycle before each capture;
- done lasts one clock and falls in the address-hold cycle with the address unchanged;
- a zero output-enable delay makes the two strobes fall together.

Only the bench scenarios can show the rest, because they need a known programming of the fields. That covers the exact strobe length of max(W,D)+1 for several W and D pairs, the exact output-enable offset, and the captured word matching the memory model. It also covers per-bank isolation of a field write and the silent discard of a request made while busy.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_HOLD   = 2'd2
  } smem_state_e;
endpackage

// File: rtl/smem_cfg_regs.sv
module smem_cfg_regs #(
  parameter int NUM_BANKS = 4,
  parameter int WAIT_W    = 5,
  parameter int OED_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wbank_i,
  input  logic [WAIT_W-1:0] wwait_i,
  input  logic [OED_W-1:0]  woed_i,
  input  logic [BANK_W-1:0] rbank_i,
  output logic [WAIT_W-1:0] rwait_o,
  output logic [OED_W-1:0]  roed_o
);
  logic [WAIT_W-1:0] wait_q [NUM_BANKS];
  logic [OED_W-1:0]  oed_q  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wait_q[b] <= '0;
        oed_q[b]  <= '0;
      end else if (we_i && wbank_i == BANK_W'(b)) begin
        wait_q[b] <= wwait_i;
        oed_q[b]  <= woed_i;
      end
    end
  end

  assign rwait_o = wait_q[rbank_i];
  assign roed_o  = oed_q[rbank_i];
endmodule

// File: rtl/smem_rd_seq.sv
module smem_rd_seq
  import smem_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int WAIT_W    = 5,
  parameter int OED_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = (WAIT_W > OED_W) ? WAIT_W : OED_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [WAIT_W-1:0]    bank_wait_i,
  input  logic [OED_W-1:0]     bank_oed_i,
  output logic                 busy_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [NUM_BANKS-1:0] mem_cs_no,
  output logic                 mem_oe_no,
  input  logic [DATA_W-1:0]    mem_data_i,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rd_data_o
);
  smem_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q, last_q, req_last;
  logic [OED_W-1:0]  oed_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sample;

  // sample point never precedes a full clock of output enable
  assign req_last = (CNT_W'(bank_wait_i) > CNT_W'(bank_oed_i)) ?
                    CNT_W'(bank_wait_i) : CNT_W'(bank_oed_i);
  assign sample   = (state_q == ST_ACCESS) && (cnt_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      last_q    <= '0;
      oed_q     <= '0;
      bank_q    <= '0;
      addr_q    <= '0;
      done_o    <= 1'b0;
      rd_data_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_ACCESS;
          cnt_q   <= '0;
          last_q  <= req_last;
          oed_q   <= bank_oed_i;
          bank_q  <= req_bank_i;
          addr_q  <= req_addr_i;
        end
        ST_ACCESS: if (sample) begin
          state_q   <= ST_HOLD;
          done_o    <= 1'b1;
          rd_data_o <= mem_data_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_HOLD: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign mem_addr_o = addr_q;
  assign mem_oe_no  = !((state_q == ST_ACCESS) && (cnt_q >= CNT_W'(oed_q)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign mem_cs_no[b] = !((state_q == ST_ACCESS) && (bank_q == BANK_W'(b)));
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (&mem_cs_no && mem_oe_no && !done_o));
  p_one_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));
  p_oe_with_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(&mem_cs_no) && oed_q == '0) |-> !mem_oe_no);
  p_oe_before_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!mem_oe_no));
  p_strobes_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> ($rose(&mem_cs_no) && done_o));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && &mem_cs_no && $stable(mem_addr_o)));
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/smem_rd_ctrl.sv
module smem_rd_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int WAIT_W    = 5,
  parameter int OED_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [BANK_W-1:0]    cfg_bank_i,
  input  logic [WAIT_W-1:0]    cfg_wait_i,
  input  logic [OED_W-1:0]     cfg_oed_i,
  input  logic                 req_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [BANK_W-1:0]    req_bank_i,
  output logic                 busy_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [NUM_BANKS-1:0] mem_cs_no,
  output logic                 mem_oe_no,
  input  logic [DATA_W-1:0]    mem_data_i,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rd_data_o
);
  logic [WAIT_W-1:0] bank_wait;
  logic [OED_W-1:0]  bank_oed;

  smem_cfg_regs #(
    .NUM_BANKS(NUM_BANKS), .WAIT_W(WAIT_W), .OED_W(OED_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wbank_i (cfg_bank_i),
    .wwait_i (cfg_wait_i),
    .woed_i  (cfg_oed_i),
    .rbank_i (req_bank_i),
    .rwait_o (bank_wait),
    .roed_o  (bank_oed)
  );

  smem_rd_seq #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WAIT_W(WAIT_W), .OED_W(OED_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_addr_i  (req_addr_i),
    .req_bank_i  (req_bank_i),
    .bank_wait_i (bank_wait),
    .bank_oed_i  (bank_oed),
    .busy_o      (busy_o),
    .mem_addr_o  (mem_addr_o),
    .mem_cs_no   (mem_cs_no),
    .mem_oe_no   (mem_oe_no),
    .mem_data_i  (mem_data_i),
    .done_o      (done_o),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: tb/sim_smem_rd_ctrl.sv
module sim_smem_rd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [4:0]  cfg_wait = '0;
  logic [3:0]  cfg_oed = '0;
  logic        req = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_bank = '0;
  logic        busy, mem_oe_n, done;
  logic [23:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic [31:0] mem_data, rd_data;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // memory model: drives only while selected and output-enabled
  logic [31:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 * (i + 1) ^ (32'h0000_5A5A + i);
  assign mem_data = (!(&mem_cs_n) && !mem_oe_n) ? mem[mem_addr[3:0]] : 32'hDEAD_BEEF;

  smem_rd_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_bank_i(cfg_bank),
    .cfg_wait_i(cfg_wait), .cfg_oed_i(cfg_oed), .req_i(req), .req_addr_i(req_addr),
    .req_bank_i(req_bank), .busy_o(busy), .mem_addr_o(mem_addr), .mem_cs_no(mem_cs_n),
    .mem_oe_no(mem_oe_n), .mem_data_i(mem_data), .done_o(done), .rd_data_o(rd_data)
  );

  task automatic check(input bit ok, input string req_tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_phase = 0;       // 0 idle, 1 access, 2 hold
  int m_cnt = 0, m_last = 0, m_oed = 0, m_bank = 0;
  int m_addr = 0;
  bit m_done = 0;
  logic [31:0] m_data = '0;
  int c_wait [4] = '{0, 0, 0, 0};
  int c_oed  [4] = '{0, 0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_done = 0; m_data = '0; m_addr = 0;
      for (int b = 0; b < 4; b++) begin c_wait[b] = 0; c_oed[b] = 0; end
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (req) begin
          m_phase = 1; m_cnt = 0; m_bank = int'(req_bank); m_addr = int'(req_addr);
          m_oed = c_oed[m_bank];
          m_last = (c_wait[m_bank] > m_oed) ? c_wait[m_bank] : m_oed;
        end
      end else if (m_phase == 1) begin
        if (m_cnt == m_last) begin
          m_phase = 2; m_done = 1; m_data = mem[m_addr % 16];
        end else m_cnt++;
      end else m_phase = 0;
      if (cfg_we) begin
        c_wait[cfg_bank] = int'(cfg_wait);
        c_oed[cfg_bank]  = int'(cfg_oed);
      end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    logic [3:0] e_cs;
    e_cs = 4'hF;
    if (m_phase == 1) e_cs[m_bank] = 1'b0;
    check(busy == (m_phase != 0), "R8 busy", busy, m_phase != 0);
    check(mem_cs_n == e_cs, "R2/R5 chip select", mem_cs_n, e_cs);
    check(mem_oe_n == !(m_phase == 1 && m_cnt >= m_oed), "R3/R4 output enable",
          mem_oe_n, !(m_phase == 1 && m_cnt >= m_oed));
    check(done == m_done, "R7 done", done, m_done);
    check(rd_data == m_data, "R7 data", rd_data, m_data);
    if (m_phase != 0) check(mem_addr == 24'(m_addr), "R8 address", mem_addr, m_addr);
  end

  task automatic cfg_write(input int bank, input int w, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_bank = 2'(bank); cfg_wait = 5'(w); cfg_oed = 4'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // one read with explicit timing checks; stray_at >= 0 injects a request while busy
  task automatic do_read(input int bank, input logic [23:0] addr, input int exp_n,
                         input int exp_oe, input int stray_at);
    int n = 0, first_oe = -1;
    @(negedge clk);
    req = 1; req_bank = 2'(bank); req_addr = addr;
    @(negedge clk);
    req = 0;
    check(busy && mem_addr == addr, "R2 accept", {busy, mem_addr}, {1'b1, addr});
    check(mem_cs_n == ~(4'b1 << bank), "R2 bank select", mem_cs_n, ~(4'b1 << bank));
    while (!(&mem_cs_n) && n < 64) begin
      if (!mem_oe_n && first_oe < 0) first_oe = n;
      if (n == stray_at) begin req = 1; req_addr = addr ^ 24'h5; req_bank = 2'(bank ^ 1); end
      n++;
      @(negedge clk);
      req = 0;
    end
    check(n == exp_n, "R5 strobe cycles", n, exp_n);
    check(first_oe == exp_oe, (exp_oe == 0) ? "R3 oe offset" : "R4 oe offset", first_oe, exp_oe);
    check(mem_oe_n && &mem_cs_n, "R6 strobes released together", {mem_oe_n, mem_cs_n}, 5'h1F);
    check(done && rd_data == mem[addr[3:0]], "R7 captured word", rd_data, mem[addr[3:0]]);
    check(busy && mem_addr == addr, "R8 address hold", mem_addr, addr);
    @(negedge clk);
    check(!busy && !done, "R8 release", {busy, done}, 2'b00);
    check(rd_data == mem[addr[3:0]], "R7 data held", rd_data, mem[addr[3:0]]);
    if (stray_at >= 0) begin
      @(negedge clk);
      check(!busy && &mem_cs_n, "R9 stray request ignored", {busy, mem_cs_n}, 5'h0F);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(&mem_cs_n && mem_oe_n && !busy && !done, "R1 reset state",
          {mem_cs_n, mem_oe_n, busy, done}, 7'b1111100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(&mem_cs_n && mem_oe_n && !busy, "R1 idle", {mem_cs_n, mem_oe_n, busy}, 6'b111110);
    do_read(0, 24'h000010, 1, 0, -1);          // R10 reset fields 0/0, R5 zero wait
    cfg_write(1, 3, 0);
    do_read(1, 24'h0000A3, 4, 0, -1);          // R5 three wait states
    cfg_write(2, 2, 5);
    do_read(2, 24'h000105, 6, 5, -1);          // R4 delay beyond wait count
    cfg_write(3, 6, 2);
    do_read(3, 24'h000037, 7, 2, -1);
    cfg_write(1, 31, 15);
    do_read(1, 24'hFFFFF9, 32, 15, -1);        // R5 maximum wait
    cfg_write(2, 1, 1);
    do_read(1, 24'h00000C, 32, 15, -1);        // R10 bank1 untouched by bank2 write
    do_read(2, 24'h00000E, 2, 1, -1);          // R10 bank2 reprogrammed
    do_read(3, 24'h000042, 7, 2, 3);           // R9 request while busy
    do_read(0, 24'h000001, 1, 0, 0);           // R9 request in the first cycle
    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule